// File: doc/BRIEF.md
# Peripheral Idle and Standby Handshake Controller

This block is the power-management agent that sits beside a peripheral. It holds one 32-bit configuration word with three 2-bit fields. One field picks how the peripheral's target side answers idle requests from the system power manager. One picks how its bus-initiator side drives a standby indication. One says which clocks must be kept running while a wakeup is under way.

On the target side, the block acknowledges idle requests according to the selected policy. It can silence the peripheral's interrupt and DMA request outputs, and it can raise a target wakeup when an event arrives while the peripheral is idle. On the initiator side, it drives the standby output from the peripheral's need for its initiator port, and it can raise an initiator wakeup. The clock-keep outputs tell the clock controller which clocks are needed while either wakeup is active. The peripheral core supplies a busy flag, its raw interrupt and DMA requests, and an initiator-need flag.

Top module: `pm_idle_agent`

## Requirements
- R1: After reset the configuration reads as zero. The idle policy sits in bits 4:3, the clock-keep bits in 9:8 and the standby policy in 13:12. A write appears on `cfg_rdata` from the next cycle. Every other bit reads zero and ignores writes.
- R2: With idle policy 0 (forced), `idle_ack` rises on the clock edge after `idle_req` is sampled high. While it is held, `irq_out` and `dma_out` are low whatever the core requests.
- R3: With idle policy 1 (never idle), `idle_ack` stays low whatever `idle_req` does, and requests pass through.
- R4: With idle policy 2 or 3 (smart), `idle_ack` rises on the edge that samples `idle_req` high together with `core_busy`, `core_irq` and `core_dma` all low. While acknowledged, requests pass through. Policy 2 never raises `tgt_wakeup`.
- R5: With idle policy 3, an edge that samples `core_irq` or `core_dma` high while acknowledged sets `tgt_wakeup`. It then holds until the edge that samples `idle_req` low.
- R6: Once `idle_ack` is high it stays high while `idle_req` stays high, regardless of core activity. It drops on the edge that samples `idle_req` low.
- R7: A write that changes the idle policy while `idle_ack` is high shows at once on readback. It governs the handshake only once `idle_ack` has dropped.
- R8: Standby policy 0 drives `standby` high, and policy 1 drives it low. Policies 2 and 3 drive it to the inverse of `core_mst_need` as sampled at the previous edge. `standby` is high out of reset.
- R9: Under standby policy 3, `ini_wakeup` is high in any cycle where `standby` is high and `core_mst_need` is high. Under the other policies it stays low.
- R10: With parameter `MST_EN` at 0, the standby field reads zero, ignores writes, and `standby` stays high.
- R11: `keep_if_clk` equals bit 8 ANDed with (`tgt_wakeup` OR `ini_wakeup`). `keep_fn_clk` is the same with bit 9.
- R12: Whenever requests are not silenced under R2, `irq_out` and `dma_out` follow `core_irq` and `core_dma` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration readback |
| idle_req | input | 1 | Idle request from the power manager |
| idle_ack | output | 1 | Idle acknowledge to the power manager |
| core_busy | input | 1 | Core has target-side work in progress |
| core_irq | input | 1 | Raw interrupt request from the core |
| core_dma | input | 1 | Raw DMA request from the core |
| core_mst_need | input | 1 | Core needs its initiator port |
| irq_out | output | 1 | Gated interrupt request |
| dma_out | output | 1 | Gated DMA request |
| tgt_wakeup | output | 1 | Target-side wakeup |
| standby | output | 1 | Initiator-side standby |
| ini_wakeup | output | 1 | Initiator-side wakeup |
| keep_if_clk | output | 1 | Keep the interface clock running |
| keep_fn_clk | output | 1 | Keep the functional clock running |

## Verification
The bench builds two copies that share every input: one with `MST_EN` at 1 and one with `MST_EN` at 0. The first copy reaches every standby policy and the initiator wakeup. The second shows that standby writes are dropped and that standby is pinned high. Directed sequences cover each idle policy, a policy change in the middle of a handshake, and the wakeup and clock-keep path. Random writes, which also touch the reserved bits, are mixed with random request and activity patterns.

// File: rtl/pmh_pkg.sv
`timescale 1ns/1ps
package pmh_pkg;
  localparam int unsigned FIELD_W  = 2;
  localparam int unsigned IDLE_LSB = 3;
  localparam int unsigned CLK_LSB  = 8;
  localparam int unsigned STBY_LSB = 12;

  typedef enum logic [FIELD_W-1:0] {
    IDLE_FORCE    = 2'd0,
    IDLE_NONE     = 2'd1,
    IDLE_SMART    = 2'd2,
    IDLE_SMART_WK = 2'd3
  } idle_mode_e;

  typedef enum logic [FIELD_W-1:0] {
    STBY_FORCE    = 2'd0,
    STBY_NONE     = 2'd1,
    STBY_SMART    = 2'd2,
    STBY_SMART_WK = 2'd3
  } stby_mode_e;

  typedef struct packed {
    stby_mode_e         stby;
    logic [FIELD_W-1:0] clk_keep;
    idle_mode_e         idle;
  } cfg_t;
endpackage

// File: rtl/pmh_rst_sync.sv
`timescale 1ns/1ps
module pmh_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pmh_cfg_reg.sv
`timescale 1ns/1ps
module pmh_cfg_reg
  import pmh_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter bit          MST_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output cfg_t              cfg,
  output logic [DATA_W-1:0] rd_data
);
  cfg_t cfg_q, cfg_d;
  logic unused_wr_bits;

  assign unused_wr_bits = ^wr_data;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      cfg_d.idle     = idle_mode_e'(wr_data[IDLE_LSB +: FIELD_W]);
      cfg_d.clk_keep = wr_data[CLK_LSB +: FIELD_W];
      if (MST_EN) cfg_d.stby = stby_mode_e'(wr_data[STBY_LSB +: FIELD_W]);
      else        cfg_d.stby = STBY_FORCE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= '0;
    else if (wr_en) cfg_q <= cfg_d;
  end

  always_comb begin
    rd_data = '0;
    rd_data[IDLE_LSB +: FIELD_W] = cfg_q.idle;
    rd_data[CLK_LSB  +: FIELD_W] = cfg_q.clk_keep;
    rd_data[STBY_LSB +: FIELD_W] = cfg_q.stby;
  end

  assign cfg = cfg_q;

  // R1: written idle field visible on the next cycle
  a_r1_idle_readback: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[IDLE_LSB +: FIELD_W] == $past(wr_data[IDLE_LSB +: FIELD_W])));
  // R1: unwritten register keeps its value
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));
endmodule

// File: rtl/pmh_idle_fsm.sv
`timescale 1ns/1ps
module pmh_idle_fsm
  import pmh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idle_req,
  input  idle_mode_e cfg_mode,
  input  logic       core_busy,
  input  logic       core_irq,
  input  logic       core_dma,
  output logic       idle_ack,
  output logic       req_gate,
  output logic       tgt_wakeup
);
  logic       ack_q, ack_d;
  logic       wk_q, wk_d;
  idle_mode_e lat_q, eff_mode;
  logic       lat_en;
  logic       evt;
  logic       smart_ok;

  assign evt      = core_irq | core_dma;
  assign eff_mode = ack_q ? lat_q : cfg_mode;
  assign lat_en   = !ack_q;
  assign smart_ok = (eff_mode == IDLE_SMART || eff_mode == IDLE_SMART_WK)
                    && !core_busy && !evt;

  always_comb begin
    ack_d = 1'b0;
    if (idle_req) begin
      if (ack_q)                        ack_d = 1'b1;
      else if (eff_mode == IDLE_FORCE)  ack_d = 1'b1;
      else if (smart_ok)                ack_d = 1'b1;
    end
    wk_d = idle_req & (wk_q | (ack_q & (lat_q == IDLE_SMART_WK) & evt));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      wk_q  <= 1'b0;
      lat_q <= IDLE_FORCE;
    end else begin
      ack_q <= ack_d;
      wk_q  <= wk_d;
      if (lat_en) lat_q <= eff_mode;
    end
  end

  assign idle_ack   = ack_q;
  assign req_gate   = ack_q & (lat_q == IDLE_FORCE);
  assign tgt_wakeup = wk_q;

  a_r2_force_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_req && !ack_q && cfg_mode == IDLE_FORCE) |=> ack_q);
  a_r3_never_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_q && cfg_mode == IDLE_NONE) |=> !ack_q);
  a_r4_smart_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_q && cfg_mode[1] && (core_busy || evt)) |=> !ack_q);
  a_r5_wake_mode: assert property (@(posedge clk) disable iff (!rst_n)
    wk_q |-> (ack_q && lat_q == IDLE_SMART_WK));
  a_r6_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_req |=> (!ack_q && !wk_q));
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q && idle_req) |=> ack_q);
  a_r7_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q && $past(ack_q)) |-> $stable(lat_q));
endmodule

// File: rtl/pmh_standby.sv
`timescale 1ns/1ps
module pmh_standby
  import pmh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  stby_mode_e mode,
  input  logic       mst_need,
  output logic       standby,
  output logic       ini_wakeup
);
  logic sq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sq_q <= 1'b1;
    else        sq_q <= !mst_need;
  end

  always_comb begin
    unique case (mode)
      STBY_FORCE: standby = 1'b1;
      STBY_NONE:  standby = 1'b0;
      default:    standby = sq_q;
    endcase
  end

  assign ini_wakeup = (mode == STBY_SMART_WK) & sq_q & mst_need;

  a_r8_none_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == STBY_NONE) |-> !standby);
  a_r8_smart_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && mst_need) |=> (mode[1] -> !standby));
  a_r9_wake_in_stby: assert property (@(posedge clk) disable iff (!rst_n)
    ini_wakeup |-> (standby && mst_need));
endmodule

// File: rtl/pm_idle_agent.sv
`timescale 1ns/1ps
module pm_idle_agent
  import pmh_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter bit          MST_EN     = 1'b1,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              idle_req,
  output logic              idle_ack,
  input  logic              core_busy,
  input  logic              core_irq,
  input  logic              core_dma,
  input  logic              core_mst_need,
  output logic              irq_out,
  output logic              dma_out,
  output logic              tgt_wakeup,
  output logic              standby,
  output logic              ini_wakeup,
  output logic              keep_if_clk,
  output logic              keep_fn_clk
);
  logic rst_i_n;
  cfg_t cfg;
  logic req_gate;
  logic wake_any;

  pmh_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  pmh_cfg_reg #(.DATA_W(DATA_W), .MST_EN(MST_EN)) u_cfg (
    .clk(clk), .rst_n(rst_i_n), .wr_en(cfg_we), .wr_data(cfg_wdata),
    .cfg(cfg), .rd_data(cfg_rdata));

  pmh_idle_fsm u_idle (
    .clk(clk), .rst_n(rst_i_n), .idle_req(idle_req), .cfg_mode(cfg.idle),
    .core_busy(core_busy), .core_irq(core_irq), .core_dma(core_dma),
    .idle_ack(idle_ack), .req_gate(req_gate), .tgt_wakeup(tgt_wakeup));

  pmh_standby u_stby (
    .clk(clk), .rst_n(rst_i_n), .mode(cfg.stby), .mst_need(core_mst_need),
    .standby(standby), .ini_wakeup(ini_wakeup));

  assign irq_out     = core_irq & ~req_gate;
  assign dma_out     = core_dma & ~req_gate;
  assign wake_any    = tgt_wakeup | ini_wakeup;
  assign keep_if_clk = cfg.clk_keep[0] & wake_any;
  assign keep_fn_clk = cfg.clk_keep[1] & wake_any;

  a_r12_pass: assert property (@(posedge clk) disable iff (!rst_i_n)
    !idle_ack |-> (irq_out == core_irq && dma_out == core_dma));
  a_r11_keep_needs_wake: assert property (@(posedge clk) disable iff (!rst_i_n)
    (keep_if_clk || keep_fn_clk) |-> (tgt_wakeup || ini_wakeup));
  a_r10_stby_pinned: assert property (@(posedge clk) disable iff (!rst_i_n)
    !MST_EN |-> (standby && cfg_rdata[STBY_LSB +: FIELD_W] == 2'd0));
endmodule

// File: tb/pm_idle_agent_tb.sv
`timescale 1ns/1ps
module pm_idle_agent_tb;
  localparam int CLK_PERIOD = 10;

  logic clk, rst_n, we, req, busy, irq, dma, need;
  logic [31:0] wd;
  logic [31:0] rd [2];
  logic ack [2], irqo [2], dmao [2], tgt [2], stb [2], ini [2], kif [2], kfn [2];

  int total = 0;
  int bad = 0;

  logic [1:0] m_idle [2], m_clk [2], m_stby [2], m_lat [2];
  logic       m_ack [2], m_wk [2], m_sq [2];

  pm_idle_agent #(.MST_EN(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(we), .cfg_wdata(wd), .cfg_rdata(rd[0]),
    .idle_req(req), .idle_ack(ack[0]), .core_busy(busy), .core_irq(irq),
    .core_dma(dma), .core_mst_need(need), .irq_out(irqo[0]), .dma_out(dmao[0]),
    .tgt_wakeup(tgt[0]), .standby(stb[0]), .ini_wakeup(ini[0]),
    .keep_if_clk(kif[0]), .keep_fn_clk(kfn[0]));

  pm_idle_agent #(.MST_EN(1'b0)) u_dut_nm (
    .clk(clk), .rst_n(rst_n), .cfg_we(we), .cfg_wdata(wd), .cfg_rdata(rd[1]),
    .idle_req(req), .idle_ack(ack[1]), .core_busy(busy), .core_irq(irq),
    .core_dma(dma), .core_mst_need(need), .irq_out(irqo[1]), .dma_out(dmao[1]),
    .tgt_wakeup(tgt[1]), .standby(stb[1]), .ini_wakeup(ini[1]),
    .keep_if_clk(kif[1]), .keep_fn_clk(kfn[1]));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_idle[i] = 2'd0; m_clk[i] = 2'd0; m_stby[i] = 2'd0; m_lat[i] = 2'd0;
      m_ack[i] = 1'b0; m_wk[i] = 1'b0; m_sq[i] = 1'b1;
    end
  endtask

  task automatic compare_all();
    for (int i = 0; i < 2; i++) begin
      logic e_stb, e_ini, gate;
      logic [31:0] e_rd;
      gate  = m_ack[i] && (m_lat[i] == 2'd0);
      e_stb = (m_stby[i] == 2'd0) ? 1'b1 : (m_stby[i] == 2'd1) ? 1'b0 : m_sq[i];
      e_ini = (m_stby[i] == 2'd3) && m_sq[i] && need;
      e_rd  = (32'(m_stby[i]) << 12) | (32'(m_clk[i]) << 8) | (32'(m_idle[i]) << 3);
      check("R6 ack",       32'(ack[i]),  32'(m_ack[i]));
      check("R12 irq_out",  32'(irqo[i]), 32'(irq & ~gate));
      check("R12 dma_out",  32'(dmao[i]), 32'(dma & ~gate));
      check("R5 tgt_wake",  32'(tgt[i]),  32'(m_wk[i]));
      check("R8 standby",   32'(stb[i]),  32'(e_stb));
      check("R9 ini_wake",  32'(ini[i]),  32'(e_ini));
      check("R11 keep_if",  32'(kif[i]),  32'(m_clk[i][0] & (m_wk[i] | e_ini)));
      check("R11 keep_fn",  32'(kfn[i]),  32'(m_clk[i][1] & (m_wk[i] | e_ini)));
      check("R1 rdata",     rd[i],        e_rd);
    end
  endtask

  task automatic model_edge();
    for (int i = 0; i < 2; i++) begin
      logic [1:0] eff;
      logic nack, nwk;
      eff  = m_ack[i] ? m_lat[i] : m_idle[i];
      nack = req && (m_ack[i] || eff == 2'd0 || (eff[1] && !busy && !irq && !dma));
      nwk  = req && (m_wk[i] || (m_ack[i] && m_lat[i] == 2'd3 && (irq || dma)));
      m_lat[i] = eff; m_ack[i] = nack; m_wk[i] = nwk; m_sq[i] = !need;
      if (we) begin
        m_idle[i] = wd[4:3];
        m_clk[i]  = wd[9:8];
        m_stby[i] = (i == 0) ? wd[13:12] : 2'd0;
      end
    end
  endtask

  task automatic drive(input logic r, input logic b, input logic iq, input logic dq,
                       input logic n, input logic w, input logic [31:0] d);
    @(negedge clk);
    req = r; busy = b; irq = iq; dma = dq; need = n; we = w; wd = d;
    #1;
    compare_all();
  endtask

  task automatic finish_cycle();
    @(posedge clk);
    model_edge();
    #1;
  endtask

  task automatic step(input logic r, input logic b, input logic iq, input logic dq,
                      input logic n, input logic w, input logic [31:0] d);
    drive(r, b, iq, dq, n, w, d);
    finish_cycle();
  endtask

  task automatic wr(input logic [31:0] d);
    step(0, 0, 0, 0, 0, 1, d);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req = 0; busy = 0; irq = 0; dma = 0; need = 0; we = 0; wd = '0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R1 / R8 reset state
    check("R1 reset rdata", rd[0], 32'h0);
    check("R8 reset standby", 32'(stb[0]), 32'h1);
    check("R6 reset ack", 32'(ack[0]), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) step(0, 0, 0, 0, 0, 0, 32'h0);

    // R1 reserved bits ignored
    wr(32'hFFFF_FFFF);
    check("R1 reserved bits", rd[0], 32'h0000_3318);
    wr(32'h0);

    // R2 forced idle
    step(1, 1, 1, 1, 0, 0, 32'h0);
    check("R2 ack", 32'(ack[0]), 32'h1);
    check("R2 irq silenced", 32'(irqo[0]), 32'h0);
    check("R2 dma silenced", 32'(dmao[0]), 32'h0);
    step(0, 0, 1, 0, 0, 0, 32'h0);
    check("R6 ack drop", 32'(ack[0]), 32'h0);
    check("R12 irq resumes", 32'(irqo[0]), 32'h1);

    // R3 never idle
    wr(32'h1 << 3);
    repeat (3) step(1, 0, 1, 0, 0, 0, 32'h0);
    check("R3 no ack", 32'(ack[0]), 32'h0);
    check("R3 irq passes", 32'(irqo[0]), 32'h1);
    step(0, 0, 0, 0, 0, 0, 32'h0);

    // R4 smart idle
    wr(32'h2 << 3);
    step(1, 1, 0, 0, 0, 0, 32'h0);
    check("R4 wait busy", 32'(ack[0]), 32'h0);
    step(1, 0, 0, 0, 0, 0, 32'h0);
    check("R4 ack", 32'(ack[0]), 32'h1);
    step(1, 1, 1, 0, 0, 0, 32'h0);
    check("R6 held", 32'(ack[0]), 32'h1);
    check("R4 no wakeup", 32'(tgt[0]), 32'h0);
    check("R4 irq passes", 32'(irqo[0]), 32'h1);

    // R7 mode change mid-handshake
    step(1, 0, 0, 0, 0, 1, 32'h1 << 3);
    check("R7 ack kept", 32'(ack[0]), 32'h1);
    check("R7 readback", rd[0], 32'h8);
    step(0, 0, 0, 0, 0, 0, 32'h0);
    step(1, 0, 0, 0, 0, 0, 32'h0);
    check("R7 new mode active", 32'(ack[0]), 32'h0);
    step(0, 0, 0, 0, 0, 0, 32'h0);

    // R5 / R11 smart idle with wakeup
    wr((32'h3 << 3) | (32'h3 << 8));
    step(1, 0, 0, 0, 0, 0, 32'h0);
    check("R5 ack", 32'(ack[0]), 32'h1);
    step(1, 0, 1, 0, 0, 0, 32'h0);
    check("R5 wakeup", 32'(tgt[0]), 32'h1);
    check("R11 keep_if", 32'(kif[0]), 32'h1);
    check("R11 keep_fn", 32'(kfn[0]), 32'h1);
    step(1, 0, 0, 0, 0, 0, 32'h0);
    check("R5 wakeup held", 32'(tgt[0]), 32'h1);
    step(0, 0, 0, 0, 0, 0, 32'h0);
    check("R5 wakeup clear", 32'(tgt[0]), 32'h0);

    // R8 / R10 standby
    wr(32'h2 << 12);
    check("R10 field dropped", rd[1], 32'h0);
    step(0, 0, 0, 0, 1, 0, 32'h0);
    check("R8 smart low", 32'(stb[0]), 32'h0);
    check("R10 pinned high", 32'(stb[1]), 32'h1);
    step(0, 0, 0, 0, 0, 0, 32'h0);
    check("R8 smart high", 32'(stb[0]), 32'h1);
    wr(32'h1 << 12);
    check("R8 none low", 32'(stb[0]), 32'h0);
    wr(32'h3 << 12);
    step(0, 0, 0, 0, 0, 0, 32'h0);
    drive(0, 0, 0, 0, 1, 0, 32'h0);
    check("R9 ini wakeup", 32'(ini[0]), 32'h1);
    check("R10 no ini wakeup", 32'(ini[1]), 32'h0);
    finish_cycle();
    check("R9 wakeup ends", 32'(ini[0]), 32'h0);

    // random phase
    for (int c = 0; c < 4000; c++) begin
      logic r, w;
      logic [31:0] d;
      r = req;
      if (($urandom % 8) == 0) r = ~req;
      w = (($urandom % 16) == 0);
      d = $urandom;
      step(r, ($urandom % 2) == 0, ($urandom % 4) == 0, ($urandom % 6) == 0,
           ($urandom % 3) == 0, w, d);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule